// File: doc/BRIEF.md
# Lane Event Counter

This block is a debug counter that sits inside a serial link controller. It watches a wide vector of single-cycle event strobes and tallies one of them. Each strobe belongs to one event group, one event number within that group, and one lane. Software picks the group, the event and the lane, clears the tally, and starts or stops counting. It does all of this through one control word and reads the result from a read-only data word.

Enable and clear are command codes, not single bits. Only the defined codes act, and every other code leaves the state as it is. The tally is never cleared by a change of selection, only by the clear command. The counter wraps silently at its width, which is 32 bits by default.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the control word reads 0x00000004 (counting off) and the data word reads 0.
- R2: The control word sits at offset 0x08 and reads back these fields: group in bits 27:24, event number in bits 23:16, lane in bits 11:8, bit 7 = 1 while counting is on, and bits 4:2 = 3 when on or 1 when off. All other bits, including the clear field in 1:0, read 0.
- R3: A read strobe returns data on `reg_rdata` one clock later. Offset 0x0C returns the count, zero-extended to 32 bits. Any other offset except 0x08 returns 0. Writes to 0x0C have no effect.
- R4: Writing enable code 3 in bits 4:2 turns counting on, and code 1 turns it off. Any other code leaves the on/off state unchanged.
- R5: While counting is on (state before the edge), every clock edge at which the selected strobe is high adds exactly 1 to the count. The count holds otherwise.
- R6: Writing clear code 1 in bits 1:0 sets the count to 0. This wins over an increment on the same edge. Clear codes 0, 2 and 3 leave the count unchanged.
- R7: A control write that changes only the group, event or lane selection keeps the count.
- R8: The count wraps modulo 2^CNT_W.
- R9: Strobe bit ((group-6)*24 + event)*4 + lane carries event `event` of group `group` on lane `lane`, with 2 groups starting at 6, 24 events and 4 lanes by default. Strobes of any other index are ignored. A selection outside these ranges counts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_stb | input | NUM_GRP*NUM_EVT*NUM_LANES | Per-lane event strobes |

## Verification
The checker watches four things on every cycle:
- the counter steps by exactly one only on an enabled hit;
- the count is zero right after a clear command;
- the on/off state changes only on a control write, and a write with code 3 turns it on;
- unmapped reads return zero.

Only the bench scenarios can show the rest. These are the exact field layout on readback, the strobe-index mapping for many selections, and the rejection of out-of-range selections. They also cover the persistence of the count across selection changes and wrap-around, shown on a second instance with a narrow counter.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int CTRL_OFS = 8;
  localparam int DATA_OFS = 12;

  localparam int GRP_LSB  = 24;
  localparam int EVT_LSB  = 16;
  localparam int LANE_LSB = 8;
  localparam int STAT_BIT = 7;
  localparam int EN_LSB   = 2;

  localparam logic [2:0] EN_ON  = 3'd3;
  localparam logic [2:0] EN_OFF = 3'd1;
  localparam logic [1:0] CLR_GO = 2'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;
endpackage

// File: rtl/lec_ctrl.sv
module lec_ctrl
  import lec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic [3:0]  w_grp,
  input  logic [7:0]  w_evt,
  input  logic [3:0]  w_lane,
  input  logic [2:0]  w_en,
  input  logic [1:0]  w_clr,
  output sel_t        sel,
  output logic        cnt_on,
  output logic        clr_cmd,
  output logic [31:0] ctrl_word
);
  sel_t sel_q;
  logic on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      on_q  <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q <= '{grp: w_grp, evt: w_evt, lane: w_lane};
      if (w_en == EN_ON)       on_q <= 1'b1;
      else if (w_en == EN_OFF) on_q <= 1'b0;
    end
  end

  assign clr_cmd = wr_ctrl && (w_clr == CLR_GO);
  assign sel     = sel_q;
  assign cnt_on  = on_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[GRP_LSB+:4]  = sel_q.grp;
    ctrl_word[EVT_LSB+:8]  = sel_q.evt;
    ctrl_word[LANE_LSB+:4] = sel_q.lane;
    ctrl_word[STAT_BIT]    = on_q;
    ctrl_word[EN_LSB+:3]   = on_q ? EN_ON : EN_OFF;
  end
endmodule

// File: rtl/lec_select.sv
module lec_select
  import lec_pkg::*;
#(
  parameter int GRP_BASE  = 6,
  parameter int NUM_GRP   = 2,
  parameter int NUM_EVT   = 24,
  parameter int NUM_LANES = 4,
  localparam int STB_W = NUM_GRP * NUM_EVT * NUM_LANES
) (
  input  sel_t             sel,
  input  logic [STB_W-1:0] evt_stb,
  output logic             hit
);
  logic [NUM_GRP-1:0]   g_oh;
  logic [NUM_EVT-1:0]   e_oh;
  logic [NUM_LANES-1:0] l_oh;
  logic [STB_W-1:0]     match;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    assign g_oh[g] = (sel.grp == 4'(GRP_BASE + g));
  end
  for (genvar e = 0; e < NUM_EVT; e++) begin : e_dec
    assign e_oh[e] = (sel.evt == 8'(e));
  end
  for (genvar l = 0; l < NUM_LANES; l++) begin : l_dec
    assign l_oh[l] = (sel.lane == 4'(l));
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_m
    for (genvar e = 0; e < NUM_EVT; e++) begin : e_m
      for (genvar l = 0; l < NUM_LANES; l++) begin : l_m
        assign match[(g*NUM_EVT + e)*NUM_LANES + l] = g_oh[g] & e_oh[e] & l_oh[l];
      end
    end
  end

  assign hit = |(match & evt_stb);
endmodule

// File: rtl/lec_count.sv
module lec_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
  import lec_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int GRP_BASE  = 6,
  parameter int NUM_GRP   = 2,
  parameter int NUM_EVT   = 24,
  parameter int NUM_LANES = 4,
  localparam int STB_W = NUM_GRP * NUM_EVT * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [STB_W-1:0]  evt_stb
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);

  logic        is_ctrl, is_data, wr_ctrl;
  sel_t        sel;
  logic        cnt_on, clr_cmd, hit;
  logic [31:0] ctrl_word;
  logic [CNT_W-1:0] cnt;
  logic [31:0] rdata_q;
  logic        unused_wbits;

  assign is_ctrl = (reg_addr == A_CTRL);
  assign is_data = (reg_addr == A_DATA);
  assign wr_ctrl = reg_wr && is_ctrl;
  assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[15:12], reg_wdata[7:5]};

  lec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl),
    .w_grp(reg_wdata[GRP_LSB+:4]), .w_evt(reg_wdata[EVT_LSB+:8]),
    .w_lane(reg_wdata[LANE_LSB+:4]), .w_en(reg_wdata[EN_LSB+:3]),
    .w_clr(reg_wdata[1:0]),
    .sel(sel), .cnt_on(cnt_on), .clr_cmd(clr_cmd), .ctrl_word(ctrl_word)
  );

  lec_select #(
    .GRP_BASE(GRP_BASE), .NUM_GRP(NUM_GRP), .NUM_EVT(NUM_EVT), .NUM_LANES(NUM_LANES)
  ) u_sel (
    .sel(sel), .evt_stb(evt_stb), .hit(hit)
  );

  lec_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_cmd), .inc(cnt_on && hit), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      if (is_ctrl)      rdata_q <= ctrl_word;
      else if (is_data) rdata_q <= 32'(cnt);
      else              rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/lane_evt_counter_chk.sv
module lane_evt_counter_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              cnt_on,
  input logic              hit,
  input logic [CNT_W-1:0]  cnt
);
  logic ctrl_wr, clr_w, mapped;
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(8));
  assign clr_w   = ctrl_wr && (reg_wdata[1:0] == 2'd1);
  assign mapped  = (reg_addr == ADDR_W'(8)) || (reg_addr == ADDR_W'(12));

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> (cnt == '0));

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_w && cnt_on && hit) |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_w && !(cnt_on && hit)) |=> $stable(cnt));

  // R4
  en_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(cnt_on));

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[4:2] == 3'd3) |=> cnt_on);

  // R3
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !mapped) |=> (reg_rdata == 32'd0));
endmodule

bind lane_evt_counter lane_evt_counter_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_on(cnt_on), .hit(hit), .cnt(cnt)
);

// File: tb/lane_evt_counter_tb_top.sv
`timescale 1ns/1ps
module lane_evt_counter_tb_top;
  localparam int STB_W = 2 * 24 * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_m, rdata_n;
  logic [STB_W-1:0] stb = '0;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  lane_evt_counter dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_m), .evt_stb(stb)
  );

  lane_evt_counter #(.CNT_W(8)) dut_n (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .evt_stb(stb)
  );

  // {grp, evt, lane, selected pulses, other-lane pulses, expected count}
  localparam logic [39:0] VEC [6] = '{
    {4'd6, 8'h00, 4'd0, 8'd5,  8'd3, 8'd5},
    {4'd6, 8'h06, 4'd3, 8'd10, 8'd4, 8'd10},
    {4'd7, 8'h17, 4'd1, 8'd7,  8'd7, 8'd7},
    {4'd7, 8'h0B, 4'd2, 8'd1,  8'd9, 8'd1},
    {4'd6, 8'h02, 4'd2, 8'd0,  8'd6, 8'd0},
    {4'd7, 8'h00, 4'd3, 8'd33, 8'd2, 8'd33}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sidx(int g, int e, int l);
    return ((g - 6) * 24 + e) * 4 + l;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_ctrl(int g, int e, int l, logic [2:0] en, logic [1:0] clr);
    wr(8'h08, (32'(g) << 24) | (32'(e) << 16) | (32'(l) << 8) | (32'(en) << 2) | 32'(clr));
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] m, output logic [31:0] n);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    m = rdata_m; n = rdata_n;
  endtask

  task automatic pulse(int idx, int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      stb = '0; stb[idx] = 1'b1;
    end
    @(negedge clk);
    stb = '0;
  endtask

  task automatic pulse_all(int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      stb = '1;
    end
    @(negedge clk);
    stb = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] m, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h08, m, n); chk("R1 ctrl", m, 32'h4);
    rd(8'h0C, m, n); chk("R1 data", m, 32'h0);

    // R5 R9 table walk
    for (int v = 0; v < 6; v++) begin
      int g, e, l, ns, no, ex;
      g = int'(VEC[v][39:36]); e = int'(VEC[v][35:28]); l = int'(VEC[v][27:24]);
      ns = int'(VEC[v][23:16]); no = int'(VEC[v][15:8]); ex = int'(VEC[v][7:0]);
      wr_ctrl(g, e, l, 3'd3, 2'd1);
      pulse(sidx(g, e, l), ns);
      pulse(sidx(g, e, l ^ 1), no);
      wr_ctrl(g, e, l, 3'd1, 2'd0);
      rd(8'h0C, m, n); chk($sformatf("R5 R9 vector %0d", v), m, 32'(ex));
    end

    // R2 readback, unused bits and clear code 2 ignored
    wr(8'h08, 32'h0712_028C | 32'hF000_F060 | 32'h2);
    rd(8'h08, m, n); chk("R2 ctrl fields", m, 32'h0712_028C);

    // R4 invalid enable codes keep state
    wr_ctrl(7, 8'h12, 2, 3'd0, 2'd0);
    rd(8'h08, m, n); chk("R4 code0 keeps on", m, 32'h0712_028C);
    wr_ctrl(7, 8'h12, 2, 3'd1, 2'd0);
    wr_ctrl(7, 8'h12, 2, 3'd7, 2'd0);
    rd(8'h08, m, n); chk("R4 code7 keeps off", m, 32'h0712_0204);

    // R4 counting off ignores strobes
    wr_ctrl(6, 3, 1, 3'd3, 2'd1);
    pulse(sidx(6, 3, 1), 4);
    wr_ctrl(6, 3, 1, 3'd1, 2'd0);
    pulse(sidx(6, 3, 1), 6);
    rd(8'h0C, m, n); chk("R4 off holds", m, 32'd4);

    // R7 reselect keeps count
    wr_ctrl(7, 5, 0, 3'd1, 2'd0);
    rd(8'h0C, m, n); chk("R7 reselect keeps", m, 32'd4);

    // R6 clear codes 2/3 ignored, code 1 clears
    wr_ctrl(7, 5, 0, 3'd1, 2'd3);
    rd(8'h0C, m, n); chk("R6 code3 ignored", m, 32'd4);
    wr_ctrl(7, 5, 0, 3'd1, 2'd1);
    rd(8'h0C, m, n); chk("R6 code1 clears", m, 32'd0);

    // R6 clear beats increment
    wr_ctrl(6, 0, 0, 3'd3, 2'd1);
    @(negedge clk); stb = '1;
    wr_ctrl(6, 0, 0, 3'd3, 2'd1);
    stb = '0;
    wr_ctrl(6, 0, 0, 3'd1, 2'd0);
    rd(8'h0C, m, n); chk("R6 clear wins", m, 32'd0);

    // R3 data write ignored, unmapped reads zero
    wr_ctrl(6, 4, 2, 3'd3, 2'd1);
    pulse(sidx(6, 4, 2), 3);
    wr_ctrl(6, 4, 2, 3'd1, 2'd0);
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, m, n); chk("R3 data write ignored", m, 32'd3);
    rd(8'h10, m, n); chk("R3 unmapped read", m, 32'd0);
    rd(8'h09, m, n); chk("R3 near-ctrl read", m, 32'd0);

    // R9 out-of-range selections count nothing
    wr_ctrl(5, 0, 0, 3'd3, 2'd1);
    pulse_all(5);
    wr_ctrl(6, 24, 0, 3'd3, 2'd0);
    pulse_all(5);
    wr_ctrl(6, 0, 4, 3'd3, 2'd0);
    pulse_all(5);
    wr_ctrl(6, 0, 4, 3'd1, 2'd0);
    rd(8'h0C, m, n); chk("R9 out of range", m, 32'd0);

    // R8 wrap on the narrow instance, full count on the wide one
    wr_ctrl(6, 1, 0, 3'd3, 2'd1);
    pulse(sidx(6, 1, 0), 258);
    wr_ctrl(6, 1, 0, 3'd1, 2'd0);
    rd(8'h0C, m, n);
    chk("R8 wide count", m, 32'd258);
    chk("R8 narrow wrap", n, 32'd2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule